// File: doc/BRIEF.md
# Cache Policy Control Register and Attribute Resolver

This block holds the 32-bit control word of a level-one cache subsystem. From that word and the attributes of each memory access it works out the data-cache policy the access actually gets. Software reaches the word through a simple register bus. A write lands on the clock edge that samples the strobe. A read answers one cycle later with a registered response. Three control bits are implemented. The rest of the word is reserved.

Two of the bits rewrite the policy at run time. One sends every cacheable access to write-through. The other selects how cacheable shareable accesses are handled: they either bypass the cache or use write-through. The third bit turns off error correction in both caches. It drives a level-type `ecc_en` output that the cache arrays sample. Build parameters say whether a data cache, an instruction cache and ECC are present. A bit that a missing feature would control reads as a fixed constant and ignores writes.

The resolved policy is encoded as 2'b00 non-cacheable, 2'b01 write-through and 2'b10 write-back. It is combinational from the access attributes and the current register contents.

Top module: `cpc_top`

## Requirements
- R1: Bits [31:3] of a read response are always zero. Writing ones to them has no visible effect.
- R2: After reset, bit 2 and bit 0 read 0 and bit 1 reads its forced value if it has one, otherwise 0. This means `ecc_en` is 1 out of reset whenever ECC can be turned off.
- R3: A cycle with `bus_sel`=1, `bus_we`=1 and `bus_addr`=`REG_ADDR` stores the writable bits at that clock edge. A write to any other address leaves the register unchanged. A read of any other address returns zero.
- R4: A cycle with `bus_sel`=1 and `bus_we`=0 gives `bus_rvalid`=1 in the following cycle, and only then. `bus_rdata` then holds the register value as read in the strobe cycle.
- R5: Without a data cache, bit 2 and bit 0 read 0 and ignore writes, and the policy output is always non-cacheable (2'b00).
- R6: Bit 1 reads 1 and ignores writes when ECC is absent, or when both caches are absent. Otherwise it reads 0 and ignores writes when the data cache is absent. In every other build it is writable.
- R7: An access with `acc_cacheable`=0 always resolves to non-cacheable.
- R8: A cacheable access with `acc_shareable`=1 resolves to non-cacheable when bit 0 is 0 and to write-through when bit 0 is 1. Neither `acc_writeback` nor bit 2 changes this.
- R9: A cacheable access with `acc_shareable`=0 resolves to write-through when bit 2 is 1. Otherwise it resolves to write-back if `acc_writeback`=1 and to write-through if `acc_writeback`=0.
- R10: `ecc_en` equals the inverse of bit 1. It changes only on the clock edge of a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rvalid | output | 1 | Read response valid, one cycle after the strobe |
| acc_cacheable | input | 1 | Access is normal cacheable memory |
| acc_shareable | input | 1 | Access is shareable |
| acc_writeback | input | 1 | Programmed policy: 1 = write-back, 0 = write-through |
| pol_out | output | 2 | Effective policy: 00 non-cacheable, 01 write-through, 10 write-back |
| ecc_en | output | 1 | ECC enable level for the cache arrays |

## Verification
A register write and the resolution of an access can fall in the same cycle. In that cycle the policy must still follow the old contents, and from the next cycle it must follow the new ones. The bench provokes this by driving random access attributes while each write strobe is high. It compares `pol_out` just before the edge against the previous model value, and again after the edge against the updated one. All eight build combinations run side by side on the same bus stimulus, so the forced-bit rules and the overrides are judged together.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

  typedef enum logic [1:0] {
    POL_NC = 2'b00,
    POL_WT = 2'b01,
    POL_WB = 2'b10
  } cpc_pol_e;

  localparam int unsigned CTL_W      = 3;
  localparam int unsigned BIT_SHWT   = 0;
  localparam int unsigned BIT_ECCOFF = 1;
  localparam int unsigned BIT_FWT    = 2;

  // Bits software may change for a given build.
  function automatic logic [CTL_W-1:0] wr_mask(bit has_d, bit has_e);
    logic [CTL_W-1:0] m;
    m = '0;
    m[BIT_SHWT]   = has_d;
    m[BIT_FWT]    = has_d;
    m[BIT_ECCOFF] = has_d & has_e;
    return m;
  endfunction

  // Constant value of the bits that are not writable.
  function automatic logic [CTL_W-1:0] fixed_val(bit has_d, bit has_i, bit has_e);
    logic [CTL_W-1:0] v;
    v = '0;
    v[BIT_ECCOFF] = !has_e || (!has_d && !has_i);
    return v;
  endfunction

  // Effective data-cache policy for one access.
  function automatic cpc_pol_e resolve(bit has_d, logic [CTL_W-1:0] ctl,
                                       logic cach, logic shr, logic wb);
    cpc_pol_e p;
    if (!has_d || !cach)  p = POL_NC;
    else if (shr)         p = ctl[BIT_SHWT] ? POL_WT : POL_NC;
    else if (ctl[BIT_FWT]) p = POL_WT;
    else                  p = wb ? POL_WB : POL_WT;
    return p;
  endfunction

endpackage

// File: rtl/cpc_ctrl_reg.sv
module cpc_ctrl_reg
  import cpc_pkg::*;
#(
  parameter bit HAS_DCACHE = 1'b1,
  parameter bit HAS_ICACHE = 1'b1,
  parameter bit HAS_ECC    = 1'b1,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h0A0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic [CTL_W-1:0]  ctl_bits
);

  localparam logic [CTL_W-1:0] WR_MASK   = wr_mask(HAS_DCACHE, HAS_ECC);
  localparam logic [CTL_W-1:0] FIXED_VAL = fixed_val(HAS_DCACHE, HAS_ICACHE, HAS_ECC);
  localparam int unsigned      RSVD_W    = DATA_W - CTL_W;

  logic addr_hit, wr_hit, rd_fire, rd_hit;
  logic wdata_unused;

  assign addr_hit     = (bus_addr == REG_ADDR);
  assign wr_hit       = bus_sel & bus_we & addr_hit;
  assign rd_fire      = bus_sel & ~bus_we;
  assign rd_hit       = rd_fire & addr_hit;
  assign wdata_unused = ^bus_wdata;

  for (genvar b = 0; b < CTL_W; b++) begin : g_bit
    if (WR_MASK[b]) begin : g_rw
      logic bq;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bq <= 1'b0;
        else if (wr_hit) bq <= bus_wdata[b];
      end
      assign ctl_bits[b] = bq;
    end else begin : g_ro
      assign ctl_bits[b] = FIXED_VAL[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_fire;
      if (rd_fire) bus_rdata <= rd_hit ? {{RSVD_W{1'b0}}, ctl_bits} : '0;
    end
  end

  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> (bus_rdata[DATA_W-1:CTL_W] == '0));

  // R4
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> bus_rvalid);

  // R4
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !bus_rvalid);

  // R10
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(ctl_bits));

endmodule

// File: rtl/cpc_policy.sv
module cpc_policy
  import cpc_pkg::*;
#(
  parameter bit HAS_DCACHE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] ctl_bits,
  input  logic             acc_cacheable,
  input  logic             acc_shareable,
  input  logic             acc_writeback,
  output cpc_pol_e         pol
);

  logic shared_path, force_path;

  assign shared_path = acc_cacheable & acc_shareable;
  assign force_path  = acc_cacheable & ~acc_shareable & ctl_bits[BIT_FWT];

  assign pol = resolve(HAS_DCACHE, ctl_bits, acc_cacheable, acc_shareable, acc_writeback);

  // R7
  nc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_cacheable |-> (pol == POL_NC));

  // R8
  shared_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_path && !ctl_bits[BIT_SHWT]) |-> (pol == POL_NC));

  // R9
  force_wt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_path |-> (pol != POL_WB));

  if (!HAS_DCACHE) begin : g_nod
    // R5
    no_dcache_nc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pol == POL_NC);
  end

endmodule

// File: rtl/cpc_top.sv
module cpc_top
  import cpc_pkg::*;
#(
  parameter bit HAS_DCACHE = 1'b1,
  parameter bit HAS_ICACHE = 1'b1,
  parameter bit HAS_ECC    = 1'b1,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h0A0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              acc_cacheable,
  input  logic              acc_shareable,
  input  logic              acc_writeback,
  output logic [1:0]        pol_out,
  output logic              ecc_en
);

  logic [CTL_W-1:0] ctl_bits;
  cpc_pol_e         pol;

  cpc_ctrl_reg #(
    .HAS_DCACHE(HAS_DCACHE), .HAS_ICACHE(HAS_ICACHE), .HAS_ECC(HAS_ECC),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .ctl_bits(ctl_bits)
  );

  cpc_policy #(.HAS_DCACHE(HAS_DCACHE)) u_pol (
    .clk(clk), .rst_n(rst_n), .ctl_bits(ctl_bits),
    .acc_cacheable(acc_cacheable), .acc_shareable(acc_shareable),
    .acc_writeback(acc_writeback), .pol(pol)
  );

  assign pol_out = pol;
  assign ecc_en  = ~ctl_bits[BIT_ECCOFF];

  // R10
  ecc_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we) |=> $stable(ecc_en));

endmodule

// File: tb/tb_cpc_top.sv
module tb_cpc_top;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam logic [ADDR_W-1:0] REG_ADDR = 12'h0A0;
  localparam int NCFG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic acc_c = 1'b0, acc_s = 1'b0, acc_wb = 1'b0;

  logic [DATA_W-1:0] rdata_w [NCFG];
  logic              rvalid_w [NCFG];
  logic [1:0]        pol_w [NCFG];
  logic              ecc_w [NCFG];

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  logic [2:0] raw = 3'b000;

  always #2 clk = ~clk;

  for (genvar k = 0; k < NCFG; k++) begin : g_cfg
    cpc_top #(
      .HAS_DCACHE((k % 2) == 1), .HAS_ICACHE(((k / 2) % 2) == 1),
      .HAS_ECC(((k / 4) % 2) == 1),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)
    ) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_w[k]),
      .bus_rvalid(rvalid_w[k]), .acc_cacheable(acc_c), .acc_shareable(acc_s),
      .acc_writeback(acc_wb), .pol_out(pol_w[k]), .ecc_en(ecc_w[k])
    );
  end

  function automatic bit cd(int k); return (k % 2) == 1; endfunction
  function automatic bit ci(int k); return ((k / 2) % 2) == 1; endfunction
  function automatic bit ce(int k); return ((k / 4) % 2) == 1; endfunction

  // Register contents as the requirements define them.
  function automatic logic [2:0] exp_bits(int k, logic [2:0] r);
    logic [2:0] v;
    v[2] = cd(k) ? r[2] : 1'b0;
    v[0] = cd(k) ? r[0] : 1'b0;
    case ({ce(k), cd(k), ci(k)})
      3'b000, 3'b001, 3'b010, 3'b011, 3'b100: v[1] = 1'b1;
      3'b101:                                 v[1] = 1'b0;
      default:                                v[1] = r[1];
    endcase
    return v;
  endfunction

  function automatic logic [1:0] exp_pol(int k, logic [2:0] b, logic c, logic s, logic w);
    if (!cd(k)) return 2'b00;
    if (!c)     return 2'b00;
    if (s)      return b[0] ? 2'b01 : 2'b00;
    if (b[2])   return 2'b01;
    return w ? 2'b10 : 2'b01;
  endfunction

  task automatic chk(string req, int k, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cfg%0d: actual %0h expected %0h", req, k, act, exp);
    end
  endtask

  task automatic check_pol_all(logic [2:0] r);
    for (int k = 0; k < NCFG; k++) begin
      string tag;
      logic [2:0] b;
      b = exp_bits(k, r);
      if (!cd(k))      tag = "R5";
      else if (!acc_c) tag = "R7";
      else if (acc_s)  tag = "R8";
      else             tag = "R9";
      chk(tag, k, {30'd0, pol_w[k]}, {30'd0, exp_pol(k, b, acc_c, acc_s, acc_wb)});
      chk("R10", k, {31'd0, ecc_w[k]}, {31'd0, ~b[1]});
    end
  endtask

  task automatic sweep_attrs();
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      acc_c = a[0]; acc_s = a[1]; acc_wb = a[2];
      #1 check_pol_all(raw);
    end
  endtask

  task automatic do_write(logic [ADDR_W-1:0] addr, logic [DATA_W-1:0] data);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = addr; bus_wdata = data;
    acc_c = 1'($urandom); acc_s = 1'($urandom); acc_wb = 1'($urandom);
    // Same-cycle access resolves with the old contents (R3).
    #1 check_pol_all(raw);
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_we = 1'b0;
    if (addr == REG_ADDR) raw = data[2:0];
    // After the edge the new contents apply (R3).
    check_pol_all(raw);
  endtask

  task automatic do_read(logic [ADDR_W-1:0] addr, string req_bits);
    bit hit;
    hit = (addr == REG_ADDR);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = addr;
    @(posedge clk);
    #1 bus_sel = 1'b0;
    for (int k = 0; k < NCFG; k++) begin
      logic [2:0] e;
      e = hit ? exp_bits(k, raw) : 3'b000;
      chk("R4", k, {31'd0, rvalid_w[k]}, 32'd1);
      chk("R1", k, {3'd0, rdata_w[k][31:3]}, 32'd0);
      if (!hit)        chk("R3", k, {29'd0, rdata_w[k][2:0]}, 32'd0);
      else if (!cd(k)) chk("R5", k, {29'd0, rdata_w[k][2], 1'b0, rdata_w[k][0]}, {29'd0, e[2], 1'b0, e[0]});
      else             chk(req_bits, k, {29'd0, rdata_w[k][2], 1'b0, rdata_w[k][0]}, {29'd0, e[2], 1'b0, e[0]});
      if (hit) chk("R6", k, {31'd0, rdata_w[k][1]}, {31'd0, e[1]});
    end
    @(posedge clk);
    #1;
    for (int k = 0; k < NCFG; k++) chk("R4", k, {31'd0, rvalid_w[k]}, 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7391));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: reset state
    @(negedge clk);
    #1 check_pol_all(3'b000);
    do_read(REG_ADDR, "R2");
    // Directed: all ones, reserved bits included (R1)
    do_write(REG_ADDR, 32'hFFFF_FFFF);
    do_read(REG_ADDR, "R3");
    sweep_attrs();
    // Write to another address is ignored (R3)
    do_write(REG_ADDR ^ 12'h004, 32'h0000_0000);
    do_read(REG_ADDR, "R3");
    do_read(REG_ADDR ^ 12'h010, "R3");
    // Shared write-through only, then force write-through only
    do_write(REG_ADDR, 32'h0000_0001);
    sweep_attrs();
    do_write(REG_ADDR, 32'h0000_0004);
    sweep_attrs();
    do_write(REG_ADDR, 32'h0000_0002);
    do_read(REG_ADDR, "R3");
    sweep_attrs();
    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [ADDR_W-1:0] a;
      logic [ADDR_W-1:0] flip;
      flip = ADDR_W'(1 + ($urandom % 15));
      a = (($urandom % 4) != 0) ? REG_ADDR : (REG_ADDR ^ flip);
      do_write(a, $urandom);
      if ((n % 3) == 0) do_read((($urandom % 5) != 0) ? REG_ADDR : (REG_ADDR ^ flip), "R3");
      if ((n % 4) == 0) sweep_attrs();
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule